// File: doc/BRIEF.md
# Circular Trace Capture Buffer

This block sinks a stream of trace words into a dedicated on-chip RAM that it runs as a ring. A capture pointer steps one word per accepted trace word. When the next address would reach the exclusive end address, the pointer reloads with the base address and a sticky wrapped flag is raised. From then on, the oldest stored data begins at the capture pointer, and that data may start partway through a message. A halt-on-wrap option freezes capture after the word that wraps. That word is still stored, but it may end a message early.

Software drives the block through eight word-wide registers. The interface carries a run/hold control, a memory-kind select, base and end address registers, the capture pointer and a readback pointer. A data window returns the RAM word at the readback pointer, and each read of it advances that pointer under the same ring rule. Writes to the address registers are legalised. Alignment bits are dropped, and out-of-range values snap to the nearest legal bound. The legal range depends on the memory kind. In on-chip mode the base is fixed at zero and the end is bounded by the physical RAM. In external mode both registers span the full address space. The upper-half address registers are not implemented and read zero.

A four-state machine holds the control flow:
- HOLD: the sink is in reset.
- READY: the sink is live, but capture is off.
- RUN: capture is on.
- FROZEN: capture stopped on a wrap.

The transitions are:
- release: HOLD to READY.
- arm: READY or FROZEN to RUN.
- disarm: RUN or FROZEN to READY.
- kind-switch: any live state to READY.
- freeze: RUN to FROZEN, on a wrapping word while halt-on-wrap is set.
- drop: any live state to HOLD.

Top module: `trace_ring_sink`

## Requirements
- R1: While CTRL bit0 (live) is 0, the block is in HOLD. In HOLD, trc_ready is 0 and the registers read their defaults: base 0, end DEPTH*4, both pointers 0, CTRL 0. Writes to any register other than CTRL are ignored. Writing 0 to bit0 from any live state returns the block to HOLD with those defaults.
- R2: The memory-kind bit (CTRL bit3, 1 = external) is taken only when the block is already live. The write that releases from HOLD ignores every other bit. A change of kind goes to READY and resets base to 0, end to DEPTH*4, both pointers to 0 and the wrapped flag to 0.
- R3: trc_ready is 1 only in RUN and only when no register write occurs in the same cycle. Each accepted word is stored at the capture pointer (CTRL index 5), and the pointer then advances by 4.
- R4: When the capture pointer plus 4 is at or above the end address, the pointer reloads with the base and CTRL bit8 (wrapped) is set.
- R5: With CTRL bit2 (halt-on-wrap) set, the wrapping word is stored and the block enters FROZEN. In FROZEN, CTRL bit9 reads 1 and trc_ready is 0.
- R6: Writing CTRL with bit1 (capture) = 1 from READY or FROZEN enters RUN and clears bit8 and bit9. Writing bit1 = 0 enters READY and keeps bit8.
- R7: In on-chip mode, the base register (index 1) reads 0 and ignores writes.
- R8: In on-chip mode, the end register (index 3) stores its written value clamped to the range [8, DEPTH*4]. Writing 0 gives 8, and writing 0xFFFFFFFF gives DEPTH*4.
- R9: In external mode, writing 0 gives base 0 and end 8, and writing 0xFFFFFFFF gives 0xFFFFFFFC in both registers.
- R10: The upper-half base and end registers (indices 2 and 4) read 0 in every mode, including after a write of 0xFFFFFFFF.
- R11: A read of the data window (index 7) returns the RAM word at the readback pointer (index 6). The read then advances that pointer by 4, reloading with the base at the end address. The read leaves the wrapped flag unchanged.
- R12: Bits [1:0] of the base, end and both pointer registers always read 0. Written values have those bits dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (advances the readback pointer on index 7) |
| reg_idx | input | 3 | Register index: 0 CTRL, 1 base, 2 base high, 3 end, 4 end high, 5 capture ptr, 6 readback ptr, 7 data |
| reg_wdata | input | REG_W | Register write data |
| reg_rdata | output | REG_W | Register read data, combinational from reg_idx |
| trc_valid | input | 1 | Trace word offered |
| trc_data | input | REG_W | Trace word |
| trc_ready | output | 1 | Trace word accepted this cycle when high with trc_valid |

## Verification
The bench drives the capture pointer into a shrunken 4-word ring. It checks that the pointer reloads on the exact word that meets the end address. An off-by-one compare would either store one word past the end or wrap a word early, and the readback order would then come out wrong. With halt-on-wrap set, it offers a further word after the freeze. A design that kept accepting would overwrite the oldest entry, and the scoreboard would catch that on readback. It also tests that the kind select is ignored on the releasing write, and that both kinds clamp at the 0 and all-ones extremes. It checks that re-arming clears the wrapped flag while disarming keeps it.

// File: rtl/trs_pkg.sv
package trs_pkg;
    typedef enum logic [1:0] {
        ST_HOLD   = 2'd0,
        ST_READY  = 2'd1,
        ST_RUN    = 2'd2,
        ST_FROZEN = 2'd3
    } sink_state_e;

    localparam logic [2:0] RI_CTRL     = 3'd0;
    localparam logic [2:0] RI_BASE     = 3'd1;
    localparam logic [2:0] RI_BASE_HI  = 3'd2;
    localparam logic [2:0] RI_END      = 3'd3;
    localparam logic [2:0] RI_END_HI   = 3'd4;
    localparam logic [2:0] RI_CAP_PTR  = 3'd5;
    localparam logic [2:0] RI_RD_PTR   = 3'd6;
    localparam logic [2:0] RI_DATA     = 3'd7;

    localparam int CB_LIVE    = 0;
    localparam int CB_CAPTURE = 1;
    localparam int CB_HALTWR  = 2;
    localparam int CB_KIND    = 3;
    localparam int CB_WRAPPED = 8;
    localparam int CB_FROZEN  = 9;
endpackage

// File: rtl/trs_ram.sv
module trs_ram #(
    parameter int WORD_W = 32,
    parameter int DEPTH  = 64,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              we,
    input  logic [IDX_W-1:0]  waddr,
    input  logic [WORD_W-1:0] wdata,
    input  logic [IDX_W-1:0]  raddr,
    output logic [WORD_W-1:0] rdata
);
    logic [WORD_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/trs_ptr_step.sv
module trs_ptr_step #(
    parameter int REG_W = 32,
    localparam int STEP = REG_W / 8
) (
    input  logic [REG_W-1:0] ptr,
    input  logic [REG_W-1:0] base,
    input  logic [REG_W-1:0] lim,
    output logic [REG_W-1:0] next,
    output logic             wraps
);
    logic [REG_W:0] sum;

    always_comb begin
        sum   = {1'b0, ptr} + (REG_W+1)'(STEP);
        wraps = sum >= {1'b0, lim};
        next  = wraps ? base : sum[REG_W-1:0];
    end
endmodule

// File: rtl/trs_addr_legalize.sv
module trs_addr_legalize #(
    parameter int REG_W       = 32,
    parameter int DEPTH       = 64,
    parameter int MIN_WORDS   = 2,
    parameter bit LIMIT_FIXED = 1'b0,
    localparam int STEP  = REG_W / 8,
    localparam int ALIGN = $clog2(STEP)
) (
    input  logic             kind_ext,
    input  logic [REG_W-1:0] raw,
    output logic [REG_W-1:0] aligned,
    output logic [REG_W-1:0] base_legal,
    output logic [REG_W-1:0] end_legal
);
    localparam logic [REG_W-1:0] ONCHIP_TOP = REG_W'(DEPTH * STEP);
    localparam logic [REG_W-1:0] END_MIN    = REG_W'(MIN_WORDS * STEP);

    logic [REG_W-1:0] onchip_end;

    assign aligned = {raw[REG_W-1:ALIGN], {ALIGN{1'b0}}};

    generate
        if (LIMIT_FIXED) begin : g_end_fixed
            assign onchip_end = ONCHIP_TOP;
        end else begin : g_end_trim
            assign onchip_end = (aligned < END_MIN)    ? END_MIN :
                                (aligned > ONCHIP_TOP) ? ONCHIP_TOP : aligned;
        end
    endgenerate

    always_comb begin
        base_legal = kind_ext ? aligned : '0;
        end_legal  = kind_ext ? ((aligned < END_MIN) ? END_MIN : aligned) : onchip_end;
    end
endmodule

// File: rtl/trace_ring_sink.sv
module trace_ring_sink
    import trs_pkg::*;
#(
    parameter int REG_W       = 32,
    parameter int DEPTH       = 64,
    parameter int MIN_WORDS   = 2,
    parameter bit LIMIT_FIXED = 1'b0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_wr,
    input  logic             reg_rd,
    input  logic [2:0]       reg_idx,
    input  logic [REG_W-1:0] reg_wdata,
    output logic [REG_W-1:0] reg_rdata,
    input  logic             trc_valid,
    input  logic [REG_W-1:0] trc_data,
    output logic             trc_ready
);
    localparam int STEP  = REG_W / 8;
    localparam int ALIGN = $clog2(STEP);
    localparam int IDX_W = $clog2(DEPTH);
    localparam logic [REG_W-1:0] ONCHIP_TOP = REG_W'(DEPTH * STEP);

    sink_state_e state_q, state_d;
    logic             kind_q, haltwr_q, wrapped_q;
    logic [REG_W-1:0] base_q, end_q, wp_q, rp_q;
    logic [REG_W-1:0] wp_next, rp_next, wr_aligned, base_legal, end_legal, ram_rdata;
    logic             wp_wraps, rp_wraps_unused;
    logic             ctrl_wr, go_hold, kind_change, accept, live, frozen;

    trs_ptr_step #(.REG_W(REG_W)) u_wp_step (
        .ptr(wp_q), .base(base_q), .lim(end_q), .next(wp_next), .wraps(wp_wraps)
    );
    trs_ptr_step #(.REG_W(REG_W)) u_rp_step (
        .ptr(rp_q), .base(base_q), .lim(end_q), .next(rp_next), .wraps(rp_wraps_unused)
    );

    trs_addr_legalize #(
        .REG_W(REG_W), .DEPTH(DEPTH), .MIN_WORDS(MIN_WORDS), .LIMIT_FIXED(LIMIT_FIXED)
    ) u_legal (
        .kind_ext(kind_q), .raw(reg_wdata), .aligned(wr_aligned),
        .base_legal(base_legal), .end_legal(end_legal)
    );

    trs_ram #(.WORD_W(REG_W), .DEPTH(DEPTH)) u_ram (
        .clk(clk), .we(accept), .waddr(wp_q[ALIGN +: IDX_W]), .wdata(trc_data),
        .raddr(rp_q[ALIGN +: IDX_W]), .rdata(ram_rdata)
    );

    assign live        = (state_q != ST_HOLD);
    assign frozen      = (state_q == ST_FROZEN);
    assign ctrl_wr     = reg_wr && (reg_idx == RI_CTRL);
    assign go_hold     = ctrl_wr && !reg_wdata[CB_LIVE];
    assign kind_change = ctrl_wr && live && reg_wdata[CB_LIVE] && (reg_wdata[CB_KIND] != kind_q);
    assign trc_ready   = (state_q == ST_RUN) && !reg_wr;
    assign accept      = trc_valid && trc_ready;

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_HOLD: begin
                if (ctrl_wr && reg_wdata[CB_LIVE]) state_d = ST_READY;           // release
            end
            ST_READY, ST_RUN, ST_FROZEN: begin
                if (go_hold)                                state_d = ST_HOLD;   // drop
                else if (kind_change)                       state_d = ST_READY;  // kind-switch
                else if (ctrl_wr && !reg_wdata[CB_CAPTURE]) state_d = ST_READY;  // disarm
                else if (ctrl_wr && state_q != ST_RUN)      state_d = ST_RUN;    // arm
                else if (accept && wp_wraps && haltwr_q)    state_d = ST_FROZEN; // freeze
            end
            default: state_d = ST_HOLD;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_HOLD;
        else        state_q <= state_d;
    end

    // register file and pointers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            kind_q <= 1'b0; haltwr_q <= 1'b0; wrapped_q <= 1'b0;
            base_q <= '0; end_q <= ONCHIP_TOP; wp_q <= '0; rp_q <= '0;
        end else if (!live || go_hold) begin
            kind_q <= 1'b0; haltwr_q <= 1'b0; wrapped_q <= 1'b0;
            base_q <= '0; end_q <= ONCHIP_TOP; wp_q <= '0; rp_q <= '0;
        end else if (reg_wr) begin
            unique case (reg_idx)
                RI_CTRL: begin
                    haltwr_q <= reg_wdata[CB_HALTWR];
                    if (kind_change) begin
                        kind_q <= reg_wdata[CB_KIND]; wrapped_q <= 1'b0;
                        base_q <= '0; end_q <= ONCHIP_TOP; wp_q <= '0; rp_q <= '0;
                    end else if (reg_wdata[CB_CAPTURE] && state_q != ST_RUN) begin
                        wrapped_q <= 1'b0;
                    end
                end
                RI_BASE:    base_q <= base_legal;
                RI_END:     end_q  <= end_legal;
                RI_CAP_PTR: wp_q   <= wr_aligned;
                RI_RD_PTR:  rp_q   <= wr_aligned;
                default: ;
            endcase
        end else begin
            if (accept) begin
                wp_q <= wp_next;
                if (wp_wraps) wrapped_q <= 1'b1;
            end
            if (reg_rd && reg_idx == RI_DATA) rp_q <= rp_next;
        end
    end

    // read mux
    always_comb begin
        reg_rdata = '0;
        unique case (reg_idx)
            RI_CTRL: begin
                reg_rdata[CB_LIVE]    = live;
                reg_rdata[CB_CAPTURE] = (state_q == ST_RUN) || frozen;
                reg_rdata[CB_HALTWR]  = haltwr_q;
                reg_rdata[CB_KIND]    = kind_q;
                reg_rdata[CB_WRAPPED] = wrapped_q;
                reg_rdata[CB_FROZEN]  = frozen;
            end
            RI_BASE:    reg_rdata = base_q;
            RI_END:     reg_rdata = end_q;
            RI_CAP_PTR: reg_rdata = wp_q;
            RI_RD_PTR:  reg_rdata = rp_q;
            RI_DATA:    reg_rdata = ram_rdata;
            default:    reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/trs_checker.sv
module trs_checker #(
    parameter int REG_W     = 32,
    parameter int DEPTH     = 64,
    parameter int MIN_WORDS = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic             trc_valid,
    input logic             trc_ready,
    input logic             reg_wr,
    input logic             reg_rd,
    input logic [2:0]       reg_idx,
    input logic [REG_W-1:0] reg_wdata,
    input logic [REG_W-1:0] reg_rdata,
    input logic             kind,
    input logic [REG_W-1:0] base,
    input logic [REG_W-1:0] lim,
    input logic [REG_W-1:0] wp,
    input logic             wrapped,
    input logic             frozen
);
    localparam int STEP = REG_W / 8;
    localparam logic [REG_W:0] STEP_W = (REG_W+1)'(STEP);

    assert_hold_on_drop_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_idx == 3'd0 && !reg_wdata[0]) |=> !trc_ready);

    assert_capture_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (trc_valid && trc_ready && ({1'b0, wp} + STEP_W < {1'b0, lim}))
        |=> wp == $past(wp) + REG_W'(STEP));

    assert_wrap_reload_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (trc_valid && trc_ready && ({1'b0, wp} + STEP_W >= {1'b0, lim}))
        |=> (wrapped && wp == $past(base)));

    assert_frozen_blocks_R5: assert property (@(posedge clk) disable iff (!rst_n)
        frozen |-> !trc_ready);

    assert_onchip_base_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !kind |-> base == '0);

    assert_onchip_end_window_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !kind |-> (lim >= REG_W'(MIN_WORDS * STEP) && lim <= REG_W'(DEPTH * STEP)));

    assert_high_halves_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && (reg_idx == 3'd2 || reg_idx == 3'd4)) |-> reg_rdata == '0);

    assert_low_bits_clear_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && (reg_idx == 3'd1 || reg_idx == 3'd3 || reg_idx == 3'd5 || reg_idx == 3'd6))
        |-> reg_rdata[1:0] == 2'b00);
endmodule

bind trace_ring_sink trs_checker #(.REG_W(REG_W), .DEPTH(DEPTH), .MIN_WORDS(MIN_WORDS)) u_chk (
    .clk(clk), .rst_n(rst_n), .trc_valid(trc_valid), .trc_ready(trc_ready),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_idx(reg_idx), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .kind(kind_q), .base(base_q), .lim(end_q), .wp(wp_q),
    .wrapped(wrapped_q), .frozen(frozen)
);

// File: tb/sim_trace_ring_sink.sv
module sim_trace_ring_sink;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0, reg_rd = 1'b0;
    logic [2:0]  reg_idx = '0;
    logic [31:0] reg_wdata = '0, reg_rdata;
    logic        trc_valid = 1'b0;
    logic [31:0] trc_data = '0;
    logic        trc_ready;

    int nchk = 0, nerr = 0;
    bit done = 1'b0;

    logic [31:0] bm [64];
    logic [31:0] mwp = 0, mrp = 0, mlim = 32'h100;
    logic [31:0] exp_q [$];
    logic [31:0] act_q [$];

    trace_ring_sink u0 (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_idx(reg_idx),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .trc_valid(trc_valid),
        .trc_data(trc_data), .trc_ready(trc_ready)
    );

    always #2 clk = ~clk;

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        nchk++;
        if (got !== exp) begin
            nerr++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic reg_write(input logic [2:0] idx, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_idx = idx; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic reg_read(input logic [2:0] idx, output logic [31:0] d);
        @(negedge clk);
        reg_rd = 1'b1; reg_idx = idx;
        #1 d = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic rd_expect(input string tag, input logic [2:0] idx, input logic [31:0] exp);
        logic [31:0] d;
        reg_read(idx, d);
        chk(tag, d, exp);
    endtask

    function automatic logic [31:0] model_step(input logic [31:0] p);
        return (p + 4 >= mlim) ? 32'h0 : p + 4;
    endfunction

    // driver: offers one trace word and updates the model when acceptance is expected
    task automatic push(input string tag, input logic [31:0] d, input bit expect_take);
        @(negedge clk);
        trc_valid = 1'b1; trc_data = d;
        #1 chk(tag, {31'b0, trc_ready}, {31'b0, expect_take});
        @(negedge clk);
        trc_valid = 1'b0;
        if (expect_take) begin
            bm[mwp[7:2]] = d;
            mwp = model_step(mwp);
        end
    endtask

    // driver side of the scoreboard for the data window
    task automatic data_read;
        logic [31:0] d;
        exp_q.push_back(bm[mrp[7:2]]);
        reg_read(3'd7, d);
        act_q.push_back(d);
        mrp = model_step(mrp);
    endtask

    // monitor: pops and compares readback words (R11)
    initial begin
        forever begin
            @(negedge clk);
            while (exp_q.size() > 0 && act_q.size() > 0)
                chk("R11 readback", act_q.pop_front(), exp_q.pop_front());
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            nchk++; nerr++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 defaults in HOLD
        rd_expect("R1 ctrl", 3'd0, 32'h0);
        rd_expect("R1 base", 3'd1, 32'h0);
        rd_expect("R1 end", 3'd3, 32'h100);
        rd_expect("R1 wptr", 3'd5, 32'h0);
        chk("R1 ready", {31'b0, trc_ready}, 32'h0);
        reg_write(3'd3, 32'h40);
        rd_expect("R1 end write ignored", 3'd3, 32'h100);
        // R2 release ignores kind
        reg_write(3'd0, 32'h9);
        rd_expect("R2 release", 3'd0, 32'h1);
        // R7 base fixed on-chip
        reg_write(3'd1, 32'h20);
        rd_expect("R7 base", 3'd1, 32'h0);
        // R8 clamps, R12 alignment
        reg_write(3'd3, 32'h0);
        rd_expect("R8 end low", 3'd3, 32'h8);
        reg_write(3'd3, 32'hFFFF_FFFF);
        rd_expect("R8 end high", 3'd3, 32'h100);
        reg_write(3'd3, 32'h23);
        rd_expect("R12 end align", 3'd3, 32'h20);
        // R10 high halves
        reg_write(3'd2, 32'hFFFF_FFFF);
        reg_write(3'd4, 32'hFFFF_FFFF);
        rd_expect("R10 base hi", 3'd2, 32'h0);
        rd_expect("R10 end hi", 3'd4, 32'h0);
        // R3/R4 capture in a 4-word ring
        reg_write(3'd3, 32'h10); mlim = 32'h10;
        reg_write(3'd0, 32'h3);
        push("R3 take0", 32'hA000_0000, 1'b1);
        push("R3 take1", 32'hA000_0001, 1'b1);
        push("R3 take2", 32'hA000_0002, 1'b1);
        rd_expect("R3 wptr", 3'd5, 32'hC);
        rd_expect("R4 no wrap yet", 3'd0, 32'h3);
        push("R4 take3", 32'hA000_0003, 1'b1);
        rd_expect("R4 wptr reload", 3'd5, 32'h0);
        rd_expect("R4 wrapped", 3'd0, 32'h103);
        push("R4 take4", 32'hA000_0004, 1'b1);
        push("R4 take5", 32'hA000_0005, 1'b1);
        // R11 readback through the ring
        reg_write(3'd6, 32'h0); mrp = 0;
        for (int i = 0; i < 4; i++) data_read();
        rd_expect("R11 rptr wrapped", 3'd6, 32'h0);
        rd_expect("R11 wrap flag kept", 3'd0, 32'h103);
        // R6 disarm keeps, arm clears
        reg_write(3'd0, 32'h1);
        rd_expect("R6 disarm", 3'd0, 32'h101);
        reg_write(3'd0, 32'h3);
        rd_expect("R6 arm clears", 3'd0, 32'h3);
        // R5 halt on wrap
        reg_write(3'd0, 32'h7);
        rd_expect("R5 armed", 3'd0, 32'h7);
        push("R5 take B0", 32'hB000_0000, 1'b1);
        push("R5 take B1", 32'hB000_0001, 1'b1);
        rd_expect("R5 frozen", 3'd0, 32'h307);
        push("R5 refused", 32'hB000_0002, 1'b0);
        rd_expect("R5 wptr", 3'd5, 32'h0);
        reg_write(3'd6, 32'h0); mrp = 0;
        for (int i = 0; i < 4; i++) data_read();
        // R6 resume from frozen
        reg_write(3'd0, 32'h7);
        rd_expect("R6 resume", 3'd0, 32'h7);
        push("R6 take B3", 32'hB000_0003, 1'b1);
        // R12 pointer alignment
        reg_write(3'd5, 32'h13);
        rd_expect("R12 wptr", 3'd5, 32'h10);
        reg_write(3'd6, 32'hFF);
        rd_expect("R12 rptr", 3'd6, 32'hFC);
        // R2 kind switch
        reg_write(3'd0, 32'hB);
        rd_expect("R2 kind ctrl", 3'd0, 32'h9);
        rd_expect("R2 kind wptr", 3'd5, 32'h0);
        rd_expect("R2 kind end", 3'd3, 32'h100);
        // R9 external ranges
        reg_write(3'd1, 32'hFFFF_FFFF);
        rd_expect("R9 base high", 3'd1, 32'hFFFF_FFFC);
        reg_write(3'd1, 32'h0);
        rd_expect("R9 base low", 3'd1, 32'h0);
        reg_write(3'd3, 32'h0);
        rd_expect("R9 end low", 3'd3, 32'h8);
        reg_write(3'd3, 32'hFFFF_FFFF);
        rd_expect("R9 end high", 3'd3, 32'hFFFF_FFFC);
        reg_write(3'd2, 32'hFFFF_FFFF);
        rd_expect("R10 base hi ext", 3'd2, 32'h0);
        // R1 drop back to HOLD
        reg_write(3'd1, 32'h40);
        reg_write(3'd0, 32'h0);
        rd_expect("R1 drop ctrl", 3'd0, 32'h0);
        rd_expect("R1 drop base", 3'd1, 32'h0);
        rd_expect("R1 drop end", 3'd3, 32'h100);
        chk("R1 drop ready", {31'b0, trc_ready}, 32'h0);
        repeat (3) @(negedge clk);
        chk("R11 scoreboard drained", exp_q.size() + act_q.size(), 32'h0);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end
endmodule